// File: doc/BRIEF.md
# Sleep and Interrupt Wake-up Controller

This block sequences power-down for a small microcontroller core. The core's instruction decoder gives it a one-cycle strobe when it decodes a sleep instruction. The block also sees the per-source interrupt enable and flag vectors, the global interrupt enable, the oscillator mode and the watchdog overflow. From these it decides whether the sleep really happens. It gates the core clock, holds the core in an oscillator start-up wait on the way out, and tells the core whether to take the interrupt vector once execution resumes.

An interrupt source with both its enable and its flag set forms a wake request, whatever the global enable says. If such a request is already pending when the strobe arrives, the sleep is dropped. In that case the status bits and the watchdog are left alone. Software detects this case by finding the power-down bit still at 1. Otherwise the block enters sleep: it clears the watchdog and writes the status bits, and it stays asleep until a wake request or a watchdog overflow arrives. Crystal oscillator modes then pass through a fixed start-up count before the clock comes back.

Top module: `slp_wake_ctrl`

## Requirements
- R1: A wake request is the OR over all sources of (enable AND flag). It does not depend on `gie_i`.
- R2: A `sleep_i` strobe while running with a wake request present is a no-op: `core_clk_en_o` stays 1, `wdt_clr_o` stays 0, and `to_o` and `pd_o` keep their values.
- R3: A `sleep_i` strobe while running with no wake request takes effect at the next clock edge. From that edge `core_clk_en_o` is 0, `wdt_clr_o` is 1 for exactly one cycle, `to_o` is 1 and `pd_o` is 0, with the status bits written in the same cycle as the pulse.
- R4: While asleep, `core_clk_en_o` stays 0 until a wake, and further `sleep_i` strobes are ignored. `core_clk_en_o` rises only together with `resume_o`.
- R5: In oscillator modes 2'b00, 2'b01 and 2'b10, `core_clk_en_o` returns OST_CYCLES+1 clock edges after the first edge at which a wake cause is sampled in sleep. The default is 1024 start-up cycles.
- R6: In oscillator mode 2'b11, `core_clk_en_o` returns at the first edge at which a wake cause is sampled.
- R7: `resume_o` is a one-cycle pulse in the first cycle in which `core_clk_en_o` is back at 1. `vector_o` is 1 in that same cycle only if the wake came from an interrupt and `gie_i` was 1 at the edge where the wake was sampled.
- R8: A watchdog overflow in sleep wakes the core with `to_o` = 0, `pd_o` = 0 and `vector_o` = 0. It wins over an interrupt sampled at the same edge.
- R9: During and right after reset, `to_o` = 1, `pd_o` = 1, `core_clk_en_o` = 1, and `wdt_clr_o`, `resume_o` and `vector_o` are 0.
- R10: While running, `wdt_timeout_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | free-running clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| sleep_i | input | 1 | one-cycle strobe: sleep instruction decoded |
| int_en_i | input | NUM_SRC | per-source interrupt enables |
| int_flag_i | input | NUM_SRC | per-source interrupt flags |
| gie_i | input | 1 | global interrupt enable |
| osc_mode_i | input | 2 | oscillator mode, 2'b11 = no start-up wait |
| wdt_timeout_i | input | 1 | watchdog overflow |
| core_clk_en_o | output | 1 | core clock enable |
| wdt_clr_o | output | 1 | one-cycle watchdog and prescaler clear |
| to_o | output | 1 | timeout status bit |
| pd_o | output | 1 | power-down status bit |
| resume_o | output | 1 | pulse: core resumes execution |
| vector_o | output | 1 | with resume_o: branch to the interrupt vector |

## Verification
The checker watches on every cycle what must happen one edge after a strobe: the no-op case and the sleep entry. It also checks that the clear pulse lasts one cycle, that the clock enable rises only with the resume pulse and the vector only with the resume, and that TO and PD fall only for their permitted causes. The exact length of the start-up wait in each oscillator mode, the sampling of the global enable at wake time, the precedence of the watchdog over an interrupt, and the strobes ignored during sleep and during the start-up wait can only be shown by the bench's scenarios, which count edges from the wake.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    SLP_RUN  = 2'd0,
    SLP_DOZE = 2'd1,
    SLP_OST  = 2'd2
  } slp_state_e;

  localparam logic [1:0] OSC_NO_OST = 2'b11;
endpackage

// File: rtl/slp_wake_detect.sv
module slp_wake_detect #(
  parameter int NUM_SRC = 16
) (
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] flag_i,
  output logic               req_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = en_i[g] & flag_i[g];
  end

  assign req_o = |hit;
endmodule

// File: rtl/slp_ost_timer.sv
module slp_ost_timer #(
  parameter int OST_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(OST_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(OST_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_i,
  input  logic       wake_req_i,
  input  logic       wdt_timeout_i,
  input  logic       gie_i,
  input  logic [1:0] osc_mode_i,
  input  logic       ost_done_i,
  output logic       ost_load_o,
  output logic       ost_run_o,
  output logic       clk_en_o,
  output logic       wdt_clr_o,
  output logic       to_o,
  output logic       pd_o,
  output logic       resume_o,
  output logic       vector_o
);
  slp_state_e state_q;
  logic       vec_pend_q;
  logic       wake_cause;
  logic       irq_vec;

  assign wake_cause = wdt_timeout_i | wake_req_i;
  // watchdog wake never vectors
  assign irq_vec    = ~wdt_timeout_i & gie_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SLP_RUN;
      to_o       <= 1'b1;
      pd_o       <= 1'b1;
      wdt_clr_o  <= 1'b0;
      resume_o   <= 1'b0;
      vector_o   <= 1'b0;
      vec_pend_q <= 1'b0;
    end else begin
      wdt_clr_o <= 1'b0;
      resume_o  <= 1'b0;
      vector_o  <= 1'b0;
      unique case (state_q)
        SLP_RUN: begin
          if (sleep_i && !wake_req_i) begin
            state_q   <= SLP_DOZE;
            wdt_clr_o <= 1'b1;
            to_o      <= 1'b1;
            pd_o      <= 1'b0;
          end
        end
        SLP_DOZE: begin
          if (wake_cause) begin
            vec_pend_q <= irq_vec;
            if (wdt_timeout_i) begin
              to_o <= 1'b0;
              pd_o <= 1'b0;
            end
            if (osc_mode_i == OSC_NO_OST) begin
              state_q  <= SLP_RUN;
              resume_o <= 1'b1;
              vector_o <= irq_vec;
            end else begin
              state_q <= SLP_OST;
            end
          end
        end
        SLP_OST: begin
          if (ost_done_i) begin
            state_q  <= SLP_RUN;
            resume_o <= 1'b1;
            vector_o <= vec_pend_q;
          end
        end
        default: state_q <= SLP_RUN;
      endcase
    end
  end

  assign ost_load_o = (state_q == SLP_DOZE) && wake_cause && (osc_mode_i != OSC_NO_OST);
  assign ost_run_o  = (state_q == SLP_OST);
  assign clk_en_o   = (state_q == SLP_RUN);
endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl #(
  parameter int NUM_SRC    = 16,
  parameter int OST_CYCLES = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_i,
  input  logic [NUM_SRC-1:0] int_en_i,
  input  logic [NUM_SRC-1:0] int_flag_i,
  input  logic               gie_i,
  input  logic [1:0]         osc_mode_i,
  input  logic               wdt_timeout_i,
  output logic               core_clk_en_o,
  output logic               wdt_clr_o,
  output logic               to_o,
  output logic               pd_o,
  output logic               resume_o,
  output logic               vector_o
);
  logic wake_req;
  logic ost_load;
  logic ost_run;
  logic ost_done;

  slp_wake_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .en_i   (int_en_i),
    .flag_i (int_flag_i),
    .req_o  (wake_req)
  );

  slp_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ost_load),
    .run_i  (ost_run),
    .done_o (ost_done)
  );

  slp_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sleep_i       (sleep_i),
    .wake_req_i    (wake_req),
    .wdt_timeout_i (wdt_timeout_i),
    .gie_i         (gie_i),
    .osc_mode_i    (osc_mode_i),
    .ost_done_i    (ost_done),
    .ost_load_o    (ost_load),
    .ost_run_o     (ost_run),
    .clk_en_o      (core_clk_en_o),
    .wdt_clr_o     (wdt_clr_o),
    .to_o          (to_o),
    .pd_o          (pd_o),
    .resume_o      (resume_o),
    .vector_o      (vector_o)
  );
endmodule

// File: rtl/slp_wake_ctrl_chk.sv
module slp_wake_ctrl_chk #(
  parameter int NUM_SRC = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sleep_i,
  input logic [NUM_SRC-1:0] int_en_i,
  input logic [NUM_SRC-1:0] int_flag_i,
  input logic               wdt_timeout_i,
  input logic               core_clk_en_o,
  input logic               wdt_clr_o,
  input logic               to_o,
  input logic               pd_o,
  input logic               resume_o,
  input logic               vector_o
);
  logic pend;
  assign pend = |(int_en_i & int_flag_i);

  assert_sleep_nop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i && pend && core_clk_en_o |=> core_clk_en_o && !wdt_clr_o && $stable(to_o) && $stable(pd_o));

  assert_sleep_enter_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i && !pend && core_clk_en_o |=> !core_clk_en_o && wdt_clr_o && to_o && !pd_o);

  assert_clr_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |=> !wdt_clr_o);

  assert_pd_fall_with_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pd_o) |-> wdt_clr_o);

  assert_clk_rise_resume_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_clk_en_o) |-> resume_o);

  assert_resume_first_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> core_clk_en_o && !$past(core_clk_en_o));

  assert_vector_with_resume_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_o |-> resume_o);

  assert_to_fall_wdt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(to_o) |-> $past(wdt_timeout_i) && !$past(core_clk_en_o));

  assert_no_vector_after_wdt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_o |-> to_o);
endmodule

bind slp_wake_ctrl slp_wake_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sleep_i       (sleep_i),
  .int_en_i      (int_en_i),
  .int_flag_i    (int_flag_i),
  .wdt_timeout_i (wdt_timeout_i),
  .core_clk_en_o (core_clk_en_o),
  .wdt_clr_o     (wdt_clr_o),
  .to_o          (to_o),
  .pd_o          (pd_o),
  .resume_o      (resume_o),
  .vector_o      (vector_o)
);

// File: tb/slp_wake_ctrl_test.sv
module slp_wake_ctrl_test;
  localparam int NS  = 16;
  localparam int OST = 1024;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sleep_i = 1'b0;
  logic [NS-1:0] int_en_i = '0;
  logic [NS-1:0] int_flag_i = '0;
  logic          gie_i = 1'b0;
  logic [1:0]    osc_mode_i = 2'b00;
  logic          wdt_timeout_i = 1'b0;
  logic          core_clk_en_o, wdt_clr_o, to_o, pd_o, resume_o, vector_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic exp_to = 1'b1;
  logic exp_pd = 1'b1;

  always #10 clk_i = ~clk_i;

  slp_wake_ctrl #(.NUM_SRC(NS), .OST_CYCLES(OST)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .int_en_i(int_en_i),
    .int_flag_i(int_flag_i), .gie_i(gie_i), .osc_mode_i(osc_mode_i),
    .wdt_timeout_i(wdt_timeout_i), .core_clk_en_o(core_clk_en_o),
    .wdt_clr_o(wdt_clr_o), .to_o(to_o), .pd_o(pd_o), .resume_o(resume_o),
    .vector_o(vector_o)
  );

  function automatic logic f_wake(logic [NS-1:0] en, logic [NS-1:0] fl);
    return |(en & fl);
  endfunction

  function automatic int f_edges(logic [1:0] mode);
    return (mode == 2'b11) ? 1 : OST + 1;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk_status(input string tag);
    chk(to_o == exp_to, {tag, " to"}, int'(to_o), int'(exp_to));
    chk(pd_o == exp_pd, {tag, " pd"}, int'(pd_o), int'(exp_pd));
  endtask

  // strobe sleep with/without a pending request; returns 1 if asleep after
  task automatic strobe(input logic pend, output logic slept);
    logic [NS-1:0] en;
    logic [NS-1:0] fl;
    en = NS'($urandom) | NS'(1);
    fl = NS'($urandom) & ~en;
    if (pend) fl[$urandom % NS] = 1'b1;
    if (pend && !f_wake(en, fl)) fl = fl | en;
    int_en_i   = en;
    int_flag_i = fl;
    gie_i      = 1'b0;
    sleep_i    = 1'b1;
    step();
    sleep_i = 1'b0;
    if (f_wake(en, fl)) begin
      chk(core_clk_en_o == 1'b1, "R1 R2 nop clk", int'(core_clk_en_o), 1);
      chk(wdt_clr_o == 1'b0, "R2 nop clr", int'(wdt_clr_o), 0);
      chk_status("R2");
      slept = 1'b0;
    end else begin
      exp_to = 1'b1;
      exp_pd = 1'b0;
      chk(core_clk_en_o == 1'b0, "R1 R3 enter clk", int'(core_clk_en_o), 0);
      chk(wdt_clr_o == 1'b1, "R3 clr pulse", int'(wdt_clr_o), 1);
      chk_status("R3");
      slept = 1'b1;
    end
    int_flag_i = '0;
  endtask

  task automatic wake(input logic by_wdt, input logic by_irq, input logic gie, input logic [1:0] mode);
    int n;
    logic exp_vec;
    int_en_i      = NS'($urandom) | NS'(1 << 3);
    int_flag_i    = by_irq ? NS'(1 << 3) : '0;
    wdt_timeout_i = by_wdt;
    gie_i         = gie;
    osc_mode_i    = mode;
    exp_vec       = by_irq && !by_wdt && gie;
    if (by_wdt) begin
      exp_to = 1'b0;
      exp_pd = 1'b0;
    end
    step();
    int_flag_i    = '0;
    wdt_timeout_i = 1'b0;
    gie_i         = ~gie;  // must have been sampled at the wake edge
    osc_mode_i    = ~mode; // likewise
    n = 1;
    while (!core_clk_en_o && n < 3000) begin
      if (n == 5) sleep_i = 1'b1;
      step();
      sleep_i = 1'b0;
      n++;
    end
    chk(n == f_edges(mode), (mode == 2'b11) ? "R6 wake edges" : "R5 wake edges", n, f_edges(mode));
    chk(resume_o == 1'b1, "R7 resume", int'(resume_o), 1);
    chk(vector_o == exp_vec, by_wdt ? "R8 vector" : "R7 vector", int'(vector_o), int'(exp_vec));
    chk_status(by_wdt ? "R8" : "R7");
    step();
    chk(resume_o == 1'b0 && vector_o == 1'b0, "R7 resume pulse width", int'(resume_o), 0);
    chk(core_clk_en_o == 1'b1, "R4 running", int'(core_clk_en_o), 1);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic slept;
    void'($urandom(32'h5EED));
    @(negedge clk_i);
    chk(to_o && pd_o, "R9 reset status", int'({to_o, pd_o}), 3);
    chk(core_clk_en_o && !wdt_clr_o && !resume_o && !vector_o, "R9 reset outputs",
        int'({core_clk_en_o, wdt_clr_o, resume_o, vector_o}), 8);
    step();
    rst_ni = 1'b1;
    step();
    chk(to_o && pd_o && core_clk_en_o, "R9 after reset", int'({to_o, pd_o, core_clk_en_o}), 7);

    // R10: watchdog overflow while running
    wdt_timeout_i = 1'b1;
    step();
    wdt_timeout_i = 1'b0;
    chk(core_clk_en_o == 1'b1 && !resume_o && !wdt_clr_o, "R10 clk", int'(core_clk_en_o), 1);
    chk_status("R10");

    // R1: pending request with gie low still cancels sleep
    strobe(1'b1, slept);

    // directed: R3 sleep, strobes ignored while asleep (R4), irq wake internal osc with gie
    strobe(1'b0, slept);
    step();
    chk(wdt_clr_o == 1'b0, "R3 clr single cycle", int'(wdt_clr_o), 0);
    sleep_i = 1'b1;
    step();
    sleep_i = 1'b0;
    chk(core_clk_en_o == 1'b0 && wdt_clr_o == 1'b0, "R4 sleep strobe ignored",
        int'({core_clk_en_o, wdt_clr_o}), 0);
    chk_status("R4");
    wake(1'b0, 1'b1, 1'b1, 2'b11);

    // directed: watchdog and irq at the same edge, crystal mode
    strobe(1'b0, slept);
    wake(1'b1, 1'b1, 1'b1, 2'b01);

    // directed: crystal irq wake, gie low
    strobe(1'b0, slept);
    wake(1'b0, 1'b1, 1'b0, 2'b00);

    // random trials
    for (int t = 0; t < 14; t++) begin
      logic pend;
      pend = ($urandom % 4) == 0;
      strobe(pend, slept);
      if (slept) begin
        int idle;
        logic use_wdt;
        idle = $urandom % 6;
        for (int k = 0; k < idle; k++) begin
          step();
          chk(core_clk_en_o == 1'b0, "R4 stays asleep", int'(core_clk_en_o), 0);
        end
        use_wdt = ($urandom % 3) == 0;
        wake(use_wdt, !use_wdt || ($urandom % 2 == 0), 1'($urandom), 2'($urandom));
      end else begin
        step();
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule